// File: doc/BRIEF.md
# LIN Frame Phase State Controller

This block follows a LIN node through each phase of a frame and reports the current phase as a 4-bit code. The same code set covers master and slave operation. In master operation each code names the header field that is being sent. In slave operation each code names the field that is being recognised. A bit-timing unit outside the block supplies a one-cycle bit strobe and the sampled receive line. The block counts those strobes to find where each field ends. Software drives the mode selects, the init and sleep requests, the response direction, the response length and a request to send data.

The block also keeps three flags. One marks that a received response is waiting in the buffer. One marks that a response is being received. One holds a pending software request to send. A send request that arrives during reception is dropped. A framing or synch error reported by a neighbouring unit aborts the frame. After an error the slave goes either to Idle or straight back into break detection, depending on the level of the receive line at that moment.

Top module: `lin_phase_ctrl`

## Requirements
- R1: Codes: 0 Sleep, 1 Init, 2 Idle, 3 Break, 4 Break delimiter, 5 Synch, 6 Identifier, 7 Header complete, 8 Data, 9 Checksum. No other code is ever reported. Reset puts the block in Init. While `init_req` is high the next state is Init, ahead of every other transition, and `rx_busy` and `tx_pending` are cleared.
- R2: When Init is left, the block goes to Sleep if `sleep_req` is high and to Idle otherwise. Sleep is entered from Idle only, or directly from Init. Sleep moves to Idle when `sleep_req` goes low, or on a falling receive edge while `wake_en` is high. A falling edge while `wake_en` is low keeps the block in Sleep.
- R3: In slave LIN mode, a falling receive edge in Idle moves the block to Break. Each bit strobe with the line low (0) counts one break bit. After 10 such bits, or 11 when `brk11_sel` is 1, the block moves to Break delimiter. A strobe with the line high (1) before that count returns the block to Idle.
- R4: In slave mode, Break delimiter waits through strobes with the line low. The first strobe with the line high moves the block to Synch. Ten strobes later it moves to Identifier, and ten strobes after that to Header complete.
- R5: In master LIN mode, `hdr_req` in Idle starts the header. The block moves to Break, stays for 10 or 11 strobes (set by `brk11_sel`), then spends one strobe in Break delimiter, ten in Synch and ten in Identifier, and then reaches Header complete. The receive line has no effect on this sequence.
- R6: From Header complete the block moves to Data on the next clock in two cases: `dir_rx` is 1, or `dir_rx` is 0 and a send request is pending. Data lasts (`nbytes_m1`+1) bytes of 10 strobes each. Checksum then lasts 10 strobes, and the block returns to Idle.
- R7: An `err_evt` pulse in any state from Break to Checksum aborts the frame and clears `rx_busy`. In slave LIN mode the next state is Break if the receive line is low (0) in that cycle, and Idle if it is high. In master mode the next state is Idle.
- R8: With `uart_sel` high, only Sleep, Init, Idle and Data are ever reported. In Idle, a falling edge (receive) or a pending send request moves the block to Data for one 10-strobe byte, and it then returns to Idle. `hdr_req` has no effect.
- R9: `buf_ready` is set when a received response ends: after the Checksum byte in LIN mode, or after the byte in UART mode. It clears on `rmb_clr`, and it is held at 0 while `init_req` is high or the state is Init.
- R10: `rx_busy` is set when reception of a response begins. A `tx_req` pulse sets `tx_pending` only while `rx_busy` is 0; while `rx_busy` is 1 it is ignored. `tx_pending` clears when a transmitted response begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset into Init |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| rx_level | input | 1 | Sampled receive line, 1 = recessive |
| init_req | input | 1 | Software init request |
| sleep_req | input | 1 | Software sleep request |
| wake_en | input | 1 | Wake from Sleep on a falling receive edge |
| master_sel | input | 1 | 1 = master, 0 = slave |
| uart_sel | input | 1 | 1 = plain byte (UART) mode |
| brk11_sel | input | 1 | Break length: 1 = 11 bits, 0 = 10 bits |
| dir_rx | input | 1 | Response direction: 1 = receive, 0 = transmit |
| nbytes_m1 | input | 3 | Response data bytes minus one |
| hdr_req | input | 1 | Master request to send a header |
| tx_req | input | 1 | Software data-transmit request pulse |
| rmb_clr | input | 1 | Software clear of the buffer-ready flag |
| err_evt | input | 1 | Frame error pulse from a neighbouring checker |
| lin_state | output | 4 | Current phase code |
| rx_busy | output | 1 | Response reception in progress |
| buf_ready | output | 1 | Received data ready for software |
| tx_pending | output | 1 | Accepted transmit request waiting |

## Verification
The bench checks the phase code after every clock in slave, master and UART frames, so a field boundary that comes one strobe early or late shows up as a mismatch at the exact cycle it occurs. A break released at 10 dominant bits while the 11-bit length is selected would reach the delimiter one strobe too soon. A break that is too short would leave the block in Break instead of returning it to Idle. One error is injected while the line is low and another while it is high; a design that ignored the last bit would recover to the same state in both cases. A send request is pulsed during reception, and a design without the lock would raise `tx_pending`. Init is forced in the middle of a byte, and a design without the init clear would keep `buf_ready` set.

// File: rtl/lin_phase_ctrl.sv
module lin_phase_ctrl #(
  parameter int BYTE_TICKS = 10,
  parameter int BRK_SHORT  = 10,
  parameter int BRK_LONG   = 11,
  parameter int MAX_BYTES  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       rx_level,
  input  logic       init_req,
  input  logic       sleep_req,
  input  logic       wake_en,
  input  logic       master_sel,
  input  logic       uart_sel,
  input  logic       brk11_sel,
  input  logic       dir_rx,
  input  logic [2:0] nbytes_m1,
  input  logic       hdr_req,
  input  logic       tx_req,
  input  logic       rmb_clr,
  input  logic       err_evt,
  output logic [3:0] lin_state,
  output logic       rx_busy,
  output logic       buf_ready,
  output logic       tx_pending
);

  localparam int TMAX = (BRK_LONG > BYTE_TICKS) ? BRK_LONG : BYTE_TICKS;
  localparam int CW   = $clog2(TMAX);
  localparam int BW   = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  typedef enum logic [3:0] {
    S_SLEEP = 4'd0, S_INIT  = 4'd1, S_IDLE  = 4'd2, S_BREAK = 4'd3,
    S_DELIM = 4'd4, S_SYNCH = 4'd5, S_IDENT = 4'd6, S_HDR   = 4'd7,
    S_DATA  = 4'd8, S_CHK   = 4'd9
  } phase_t;

  phase_t        state, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [BW-1:0] bytes, byte_n;
  logic          busy_n, rdy_set, tx_take, rx_q;

  wire           fell      = rx_q & ~rx_level;
  wire  [CW-1:0] brk_last  = brk11_sel ? CW'(BRK_LONG - 1) : CW'(BRK_SHORT - 1);
  wire  [CW-1:0] byte_last = CW'(BYTE_TICKS - 1);
  wire           err_hit   = err_evt && (state >= S_BREAK) && (state <= S_CHK);
  wire           slave_lin = !master_sel && !uart_sel;

  assign lin_state = state;

  always_comb begin
    st_n    = state;
    cnt_n   = cnt;
    byte_n  = bytes;
    busy_n  = rx_busy;
    rdy_set = 1'b0;
    tx_take = 1'b0;
    if (init_req) begin
      st_n   = S_INIT;
      cnt_n  = '0;
      byte_n = '0;
      busy_n = 1'b0;
    end else if (err_hit) begin
      st_n   = (slave_lin && !rx_level) ? S_BREAK : S_IDLE;
      cnt_n  = '0;
      byte_n = '0;
      busy_n = 1'b0;
    end else begin
      case (state)
        S_INIT:  st_n = sleep_req ? S_SLEEP : S_IDLE;
        S_SLEEP: if (!sleep_req || (wake_en && fell)) st_n = S_IDLE;
        S_IDLE: begin
          cnt_n  = '0;
          byte_n = '0;
          if (sleep_req) st_n = S_SLEEP;
          else if (uart_sel) begin
            if (fell) begin
              st_n   = S_DATA;
              busy_n = 1'b1;
            end else if (tx_pending) begin
              st_n    = S_DATA;
              tx_take = 1'b1;
            end
          end else if (master_sel ? hdr_req : fell) st_n = S_BREAK;
        end
        S_BREAK: if (bit_tick) begin
          if (!master_sel && rx_level) begin
            st_n  = S_IDLE;
            cnt_n = '0;
          end else if (cnt == brk_last) begin
            st_n  = S_DELIM;
            cnt_n = '0;
          end else cnt_n = cnt + 1'b1;
        end
        S_DELIM: if (bit_tick && (master_sel || rx_level)) st_n = S_SYNCH;
        S_SYNCH, S_IDENT: if (bit_tick) begin
          if (cnt == byte_last) begin
            st_n  = (state == S_SYNCH) ? S_IDENT : S_HDR;
            cnt_n = '0;
          end else cnt_n = cnt + 1'b1;
        end
        S_HDR: begin
          cnt_n  = '0;
          byte_n = '0;
          if (dir_rx) begin
            st_n   = S_DATA;
            busy_n = 1'b1;
          end else if (tx_pending) begin
            st_n    = S_DATA;
            tx_take = 1'b1;
          end
        end
        S_DATA: if (bit_tick) begin
          if (cnt == byte_last) begin
            cnt_n = '0;
            if (uart_sel) begin
              st_n    = S_IDLE;
              rdy_set = rx_busy;
              busy_n  = 1'b0;
            end else if (bytes == BW'(nbytes_m1)) begin
              st_n   = S_CHK;
              byte_n = '0;
            end else byte_n = bytes + 1'b1;
          end else cnt_n = cnt + 1'b1;
        end
        S_CHK: if (bit_tick) begin
          if (cnt == byte_last) begin
            st_n    = S_IDLE;
            cnt_n   = '0;
            rdy_set = rx_busy;
            busy_n  = 1'b0;
          end else cnt_n = cnt + 1'b1;
        end
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_INIT;
      cnt     <= '0;
      bytes   <= '0;
      rx_busy <= 1'b0;
      rx_q    <= 1'b1;
    end else begin
      state   <= st_n;
      cnt     <= cnt_n;
      bytes   <= byte_n;
      rx_busy <= busy_n;
      rx_q    <= rx_level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       tx_pending <= 1'b0;
    else if (init_req || tx_take)     tx_pending <= 1'b0;
    else if (tx_req && !rx_busy)      tx_pending <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           buf_ready <= 1'b0;
    else if (init_req || state == S_INIT) buf_ready <= 1'b0;
    else if (rdy_set)                     buf_ready <= 1'b1;
    else if (rmb_clr)                     buf_ready <= 1'b0;
  end

endmodule

// File: rtl/lin_phase_ctrl_chk.sv
module lin_phase_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       init_req,
  input logic       err_evt,
  input logic       master_sel,
  input logic       uart_sel,
  input logic       rx_level,
  input logic [3:0] lin_state,
  input logic       rx_busy,
  input logic       buf_ready,
  input logic       tx_pending
);

  // R1
  state_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lin_state <= 4'd9);

  // R1
  init_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |=> lin_state == 4'd1);

  // R2
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lin_state == 4'd0 && $past(lin_state) != 4'd0) |->
      ($past(lin_state) == 4'd2 || $past(lin_state) == 4'd1));

  // R7
  err_dominant_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && !init_req && !master_sel && !uart_sel && !rx_level &&
     lin_state >= 4'd3 && lin_state <= 4'd9) |=> lin_state == 4'd3);

  // R8
  uart_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_sel && $past(uart_sel) &&
     ($past(lin_state) inside {4'd0, 4'd1, 4'd2, 4'd8})) |->
      (lin_state inside {4'd0, 4'd1, 4'd2, 4'd8}));

  // R9
  buf_init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lin_state == 4'd1 |-> !buf_ready);

  // R10
  tx_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_busy && !tx_pending) |=> !tx_pending);

endmodule

bind lin_phase_ctrl lin_phase_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .init_req   (init_req),
  .err_evt    (err_evt),
  .master_sel (master_sel),
  .uart_sel   (uart_sel),
  .rx_level   (rx_level),
  .lin_state  (lin_state),
  .rx_busy    (rx_busy),
  .buf_ready  (buf_ready),
  .tx_pending (tx_pending)
);

// File: tb/lin_phase_ctrl_tb.sv
module lin_phase_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0, rx_level = 1'b1;
  logic       init_req = 1'b1, sleep_req = 1'b0, wake_en = 1'b0;
  logic       master_sel = 1'b0, uart_sel = 1'b0, brk11_sel = 1'b0, dir_rx = 1'b0;
  logic [2:0] nbytes_m1 = 3'd0;
  logic       hdr_req = 1'b0, tx_req = 1'b0, rmb_clr = 1'b0, err_evt = 1'b0;
  logic [3:0] lin_state;
  logic       rx_busy, buf_ready, tx_pending;

  int checks = 0;
  int fails = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  lin_phase_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_level(rx_level),
    .init_req(init_req), .sleep_req(sleep_req), .wake_en(wake_en),
    .master_sel(master_sel), .uart_sel(uart_sel), .brk11_sel(brk11_sel),
    .dir_rx(dir_rx), .nbytes_m1(nbytes_m1), .hdr_req(hdr_req),
    .tx_req(tx_req), .rmb_clr(rmb_clr), .err_evt(err_evt),
    .lin_state(lin_state), .rx_busy(rx_busy), .buf_ready(buf_ready),
    .tx_pending(tx_pending)
  );

  task automatic cyc(input logic t, input logic r, input logic [3:0] e, input string tag);
    @(negedge clk);
    bit_tick = t;
    rx_level = r;
    @(posedge clk);
    #1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic ticks(input int n, input logic r, input logic [3:0] mid,
                       input logic [3:0] last, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, r, (i == n - 1) ? last : mid, tag);
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (lin_state !== e) begin
        fails++;
        $display("FAIL %s: state actual %0d expected %0d at %0t", t, lin_state, e, $time);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(lin_state, 1, "R1 reset state");
    chk(buf_ready, 0, "R9 reset flag");
    chk(rx_busy, 0, "R10 reset busy");
    rst_n = 1'b1;
    cyc(0, 1, 4'd1, "R1 init held");
    cyc(0, 1, 4'd1, "R1 init held");

    // R2 sleep and wake
    init_req = 0; sleep_req = 1;
    cyc(0, 1, 4'd0, "R2 init to sleep");
    cyc(0, 0, 4'd0, "R2 edge without wake");
    cyc(0, 1, 4'd0, "R2 stay sleep");
    wake_en = 1;
    cyc(0, 0, 4'd2, "R2 wake edge");
    sleep_req = 0;
    cyc(0, 1, 4'd2, "R2 idle");
    sleep_req = 1;
    cyc(0, 1, 4'd0, "R2 idle to sleep");
    sleep_req = 0;
    cyc(0, 1, 4'd2, "R2 sleep cleared");
    wake_en = 0;

    // R3 R4 R6 slave receive frame, two bytes
    dir_rx = 1; nbytes_m1 = 3'd1;
    cyc(0, 0, 4'd3, "R3 falling edge");
    ticks(10, 0, 4'd3, 4'd4, "R3 10-bit break");
    cyc(1, 0, 4'd4, "R4 delimiter waits");
    cyc(1, 1, 4'd5, "R4 delimiter valid");
    ticks(10, 1, 4'd5, 4'd6, "R4 synch");
    ticks(10, 1, 4'd6, 4'd7, "R4 identifier");
    cyc(0, 1, 4'd8, "R6 receive data");
    chk(rx_busy, 1, "R10 busy set");
    tx_req = 1;
    cyc(0, 1, 4'd8, "R10 data");
    tx_req = 0;
    chk(tx_pending, 0, "R10 tx blocked");
    ticks(20, 1, 4'd8, 4'd9, "R6 two bytes");
    ticks(10, 1, 4'd9, 4'd2, "R6 checksum");
    chk(buf_ready, 1, "R9 ready set");
    chk(rx_busy, 0, "R10 busy cleared");
    rmb_clr = 1;
    cyc(0, 1, 4'd2, "R9 clear");
    rmb_clr = 0;
    chk(buf_ready, 0, "R9 cleared by write");

    // R3 short break and 11-bit break; R7 error recovery
    brk11_sel = 1;
    cyc(0, 0, 4'd3, "R3 falling edge");
    ticks(3, 0, 4'd3, 4'd3, "R3 short break");
    cyc(1, 1, 4'd2, "R3 short break abort");
    cyc(0, 0, 4'd3, "R3 falling edge");
    ticks(10, 0, 4'd3, 4'd3, "R3 11-bit break");
    cyc(1, 0, 4'd4, "R3 11-bit break done");
    cyc(1, 1, 4'd5, "R4 delimiter");
    err_evt = 1;
    cyc(0, 0, 4'd3, "R7 error dominant");
    err_evt = 0;
    ticks(11, 0, 4'd3, 4'd4, "R7 new break");
    cyc(1, 1, 4'd5, "R4 delimiter");
    err_evt = 1;
    cyc(0, 1, 4'd2, "R7 error recessive");
    err_evt = 0;
    chk(rx_busy, 0, "R7 busy after error");

    // R5 R6 R10 master transmit frame, one byte
    brk11_sel = 0;
    tx_req = 1;
    cyc(0, 1, 4'd2, "R10 idle");
    tx_req = 0;
    chk(tx_pending, 1, "R10 tx accepted");
    master_sel = 1; dir_rx = 0; nbytes_m1 = 3'd0;
    hdr_req = 1;
    cyc(0, 1, 4'd3, "R5 header start");
    hdr_req = 0;
    ticks(10, 0, 4'd3, 4'd4, "R5 break sent");
    cyc(1, 0, 4'd5, "R5 delimiter sent");
    ticks(10, 1, 4'd5, 4'd6, "R5 synch sent");
    ticks(10, 1, 4'd6, 4'd7, "R5 identifier sent");
    cyc(0, 1, 4'd8, "R6 transmit data");
    chk(tx_pending, 0, "R10 pending taken");
    ticks(10, 1, 4'd8, 4'd9, "R6 one byte");
    ticks(10, 1, 4'd9, 4'd2, "R6 checksum");
    chk(buf_ready, 0, "R9 no ready on transmit");

    // R8 UART mode
    master_sel = 0; uart_sel = 1;
    cyc(0, 0, 4'd8, "R8 uart start");
    chk(rx_busy, 1, "R10 uart busy");
    ticks(10, 1, 4'd8, 4'd2, "R8 uart byte");
    chk(buf_ready, 1, "R9 uart ready");
    hdr_req = 1;
    cyc(0, 1, 4'd2, "R8 header ignored");
    hdr_req = 0;
    cyc(0, 0, 4'd8, "R8 uart start");
    ticks(3, 0, 4'd8, 4'd8, "R8 uart mid byte");
    init_req = 1;
    cyc(0, 1, 4'd1, "R1 init priority");
    chk(buf_ready, 0, "R9 init clears");
    chk(rx_busy, 0, "R1 init clears busy");
    init_req = 0;
    cyc(0, 1, 4'd2, "R2 init to idle");

    @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule